// File: doc/BRIEF.md
# Time-Compare Periodic Output Generator

This block drives one output pin with a square wave that is locked to a shared 64-bit time counter. Software loads a 64-bit start time through two 32-bit word writes. It then writes a nonzero half-period length, counted in reference-clock cycles. The block holds its output low until the time input reaches the start value. From that point the output goes high and inverts every length cycles.

Writing a length of zero stops the generator and pulls the output low. The expected programming order follows from this. Software first writes zero to the length, then writes the two start words, and writes the nonzero length last. The final write captures the start value and arms the block. Several instances can sit side by side on the same time bus, one per output.

Top module: `tcmp_pulse_gen`

## Requirements
- R1: While reset is asserted and after it is released, `pulse_out` is low and the generator is idle.
- R2: A write with `wr_sel`=0 loads the low 32 bits of the start time. `wr_sel`=1 loads the high 32 bits. `wr_sel`=2 writes the length. The start comparison covers all 64 bits, unsigned, so a start whose high word is above the time's high word is not reached even if its low word is smaller.
- R3: A nonzero length write arms the generator. It captures the current start words and the length. The output is low in the cycle after that write.
- R4: While armed, the output stays low until the first clock edge at which `time_now` is greater than or equal to the captured start. It is high after that edge.
- R5: Once running, the output is high for exactly L cycles, then low for L cycles, and repeats, where L is the captured length. L=1 inverts every cycle.
- R6: A zero length write makes the output low on the next clock and clears the armed or running state. The output then stays low whatever the time does.
- R7: Start-word writes made while the generator is armed or running do not change the active start or the waveform. They take effect only at the next arming.
- R8: A nonzero length write while running restarts the generator. The output goes low and the block waits again for the time input to reach the start words held at that moment.
- R9: If the captured start is already reached when the block is armed, the output goes high at the first clock edge after the arming edge.
- R10: Writes with `wr_sel`=3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 start low word, 1 start high word, 2 length |
| wr_data | input | 32 | Write data |
| time_now | input | 64 | Shared time counter value |
| pulse_out | output | 1 | Periodic output |

## Verification
The bound checker examines every cycle. It confirms that the output is low in the cycle after any length write. It confirms that the output stays low from a zero length write until the next nonzero one. It confirms that no rising edge directly follows a length write, and that every high phase ended by the generator itself lasts exactly the captured length.

Some behaviours cannot be expressed as a per-cycle property without a model of the start value, so only the bench scenarios can show them. These are:
- the exact edge on which the start compare fires, including a 32-bit word crossing and a start already in the past;
- that start-word writes during a run leave the waveform alone;
- that a restart picks up the newer start words.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

    typedef enum logic [1:0] {
        PG_IDLE  = 2'd0,
        PG_ARMED = 2'd1,
        PG_RUN   = 2'd2
    } pg_state_e;

    localparam logic [1:0] SEL_START_LO = 2'd0;
    localparam logic [1:0] SEL_START_HI = 2'd1;
    localparam logic [1:0] SEL_LENGTH   = 2'd2;

endpackage

// File: rtl/pgen_regs.sv
// Write decode and shadow start words; arm/stop decoded in the write cycle.
module pgen_regs
    import pgen_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int LEN_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [REG_W-1:0]     wr_data,
    output logic [2*REG_W-1:0]   shadow_start,
    output logic                 arm,
    output logic                 stop,
    output logic [LEN_W-1:0]     arm_len
);

    localparam int NWORDS = 2;

    typedef struct packed {
        logic [NWORDS-1:0][REG_W-1:0] word;
    } shadow_t;

    shadow_t sh_d, sh_q;
    logic    len_wr;

    always_comb begin
        sh_d = sh_q;
        for (int i = 0; i < NWORDS; i++) begin
            if (wr_en && (wr_sel == 2'(i))) begin
                sh_d.word[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign len_wr       = wr_en && (wr_sel == SEL_LENGTH);
    assign arm_len      = wr_data[LEN_W-1:0];
    assign arm          = len_wr && (arm_len != '0);
    assign stop         = len_wr && (arm_len == '0);
    assign shadow_start = {sh_q.word[SEL_START_HI], sh_q.word[SEL_START_LO]};

endmodule

// File: rtl/pgen_ge.sv
// Unsigned a >= b, built from per-slice greater/equal terms.
module pgen_ge #(
    parameter int W       = 64,
    parameter int SLICE_W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         ge
);

    localparam int NS = W / SLICE_W;

    logic [NS-1:0] slc_gt;
    logic [NS-1:0] slc_eq;

    for (genvar i = 0; i < NS; i++) begin : g_slice
        assign slc_gt[i] = a[i*SLICE_W +: SLICE_W] >  b[i*SLICE_W +: SLICE_W];
        assign slc_eq[i] = a[i*SLICE_W +: SLICE_W] == b[i*SLICE_W +: SLICE_W];
    end

    always_comb begin
        ge = 1'b1;
        for (int i = 0; i < NS; i++) begin
            ge = slc_gt[i] | (slc_eq[i] & ge);
        end
    end

endmodule

// File: rtl/pgen_wave.sv
// Arming, start wait and half-period counting.
module pgen_wave
    import pgen_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              stop,
    input  logic [LEN_W-1:0]  arm_len,
    input  logic [TIME_W-1:0] arm_start,
    input  logic              reached,
    output logic [TIME_W-1:0] act_start,
    output logic              pulse
);

    typedef struct packed {
        pg_state_e         state;
        logic              out;
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  len;
        logic [TIME_W-1:0] start;
    } wave_t;

    wave_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (stop) begin
            w_d.state = PG_IDLE;
            w_d.out   = 1'b0;
            w_d.cnt   = '0;
        end else if (arm) begin
            w_d.state = PG_ARMED;
            w_d.out   = 1'b0;
            w_d.cnt   = '0;
            w_d.len   = arm_len;
            w_d.start = arm_start;
        end else begin
            unique case (w_q.state)
                PG_ARMED: begin
                    if (reached) begin
                        w_d.state = PG_RUN;
                        w_d.out   = 1'b1;
                        w_d.cnt   = w_q.len - 1'b1;
                    end
                end
                PG_RUN: begin
                    if (w_q.cnt == '0) begin
                        w_d.out = ~w_q.out;
                        w_d.cnt = w_q.len - 1'b1;
                    end else begin
                        w_d.cnt = w_q.cnt - 1'b1;
                    end
                end
                default: begin
                    w_d.out = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '{state: PG_IDLE, out: 1'b0, cnt: '0, len: '0, start: '0};
        end else begin
            w_q <= w_d;
        end
    end

    assign act_start = w_q.start;
    assign pulse     = w_q.out;

endmodule

// File: rtl/tcmp_pulse_gen.sv
module tcmp_pulse_gen #(
    parameter int REG_W   = 32,
    parameter int LEN_W   = 32,
    parameter int SLICE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [2*REG_W-1:0] time_now,
    output logic               pulse_out
);

    localparam int TIME_W = 2 * REG_W;

    logic [TIME_W-1:0] shadow_start;
    logic [TIME_W-1:0] act_start;
    logic [LEN_W-1:0]  arm_len;
    logic              arm;
    logic              stop;
    logic              reached;

    pgen_regs #(.REG_W(REG_W), .LEN_W(LEN_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .shadow_start (shadow_start),
        .arm          (arm),
        .stop         (stop),
        .arm_len      (arm_len)
    );

    pgen_ge #(.W(TIME_W), .SLICE_W(SLICE_W)) u_ge (
        .a  (time_now),
        .b  (act_start),
        .ge (reached)
    );

    pgen_wave #(.TIME_W(TIME_W), .LEN_W(LEN_W)) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .stop      (stop),
        .arm_len   (arm_len),
        .arm_start (shadow_start),
        .reached   (reached),
        .act_start (act_start),
        .pulse     (pulse_out)
    );

endmodule

// File: rtl/tcmp_pulse_gen_chk.sv
module tcmp_pulse_gen_chk
    import pgen_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int LEN_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [REG_W-1:0] wr_data,
    input logic             pulse_out
);

    logic             len_wr;
    logic             prev_q;
    logic             idle_q;
    logic [LEN_W-1:0] run_q;
    logic [LEN_W-1:0] lat_len_q;

    assign len_wr = wr_en && (wr_sel == SEL_LENGTH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= 1'b0;
            idle_q    <= 1'b1;
            run_q     <= '0;
            lat_len_q <= '0;
        end else begin
            prev_q <= pulse_out;
            run_q  <= (pulse_out != prev_q) ? LEN_W'(1) : run_q + 1'b1;
            if (len_wr) begin
                idle_q <= (wr_data[LEN_W-1:0] == '0);
                if (wr_data[LEN_W-1:0] != '0) begin
                    lat_len_q <= wr_data[LEN_W-1:0];
                end
            end
        end
    end

    // R3 / R8: any arming or restart leaves the output low
    p_arm_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (len_wr && wr_data[LEN_W-1:0] != '0) |=> !pulse_out);

    // R6: output low after a zero length write, until re-armed
    p_stop_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q |-> !pulse_out);

    // R8: a rising edge never follows a length write directly
    p_no_rise_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> !$past(len_wr));

    // R5: a self-ended high phase lasts exactly the captured length
    p_high_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_q && !pulse_out && !$past(len_wr)) |-> (run_q == lat_len_q));

endmodule

bind tcmp_pulse_gen tcmp_pulse_gen_chk #(.REG_W(REG_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .pulse_out (pulse_out)
);

// File: tb/tcmp_pulse_gen_bench.sv
module tcmp_pulse_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [63:0] time_now = '0;
    logic        pulse_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tcmp_pulse_gen u_tcmp_pulse_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .time_now  (time_now),
        .pulse_out (pulse_out)
    );

    // reference model built from the requirements
    int          m_state = 0;   // 0 idle, 1 armed, 2 running
    logic [31:0] m_lo = '0, m_hi = '0, m_len = '0;
    logic [63:0] m_start = '0;
    longint      m_k = 0;

    function automatic logic exp_out(int st, longint k, logic [31:0] len);
        if (st != 2) return 1'b0;
        return ((k / longint'(len)) % 2) == 0;
    endfunction

    task automatic model_edge();
        if (!rst_n) begin
            m_state = 0; m_lo = '0; m_hi = '0;
        end else if (wr_en && wr_sel == 2'd2) begin
            if (wr_data == '0) m_state = 0;
            else begin
                m_state = 1; m_len = wr_data; m_start = {m_hi, m_lo};
            end
        end else begin
            if (wr_en && wr_sel == 2'd0) m_lo = wr_data;
            if (wr_en && wr_sel == 2'd1) m_hi = wr_data;
            if (m_state == 1 && time_now >= m_start) begin
                m_state = 2; m_k = 0;
            end else if (m_state == 2) begin
                m_k++;
            end
        end
    endtask

    task automatic check(string tag);
        logic e;
        e = exp_out(m_state, m_k, m_len);
        checks++;
        if (pulse_out !== e) begin
            errors++;
            $display("FAIL %s: pulse_out=%0b expected %0b at t=%0d", tag, pulse_out, e, time_now);
        end
    endtask

    // one cycle: drive at negedge, model at posedge, check at next negedge
    task automatic step(bit we, logic [1:0] sel, logic [31:0] data, int dt, string tag);
        wr_en = we; wr_sel = sel; wr_data = data;
        time_now = time_now + 64'(dt);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(int n, int dt, string tag);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, dt, tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        @(negedge clk);
        rst_n = 1'b0;
        idle(3, 1, "R1");
        rst_n = 1'b1;
        idle(3, 1, "R1");

        // R2/R3/R4/R5: basic arm and run, L=3
        time_now = 64'd100;
        step(1'b1, 2'd0, 32'd110, 1, "R2");
        step(1'b1, 2'd1, 32'd0,   1, "R2");
        step(1'b1, 2'd2, 32'd3,   1, "R3");
        idle(40, 1, "R4");
        // R6: stop, time keeps running
        step(1'b1, 2'd2, 32'd0, 1, "R6");
        idle(12, 3, "R6");

        // R5 with L=1
        step(1'b1, 2'd0, 32'(time_now[31:0] + 32'd4), 1, "R5");
        step(1'b1, 2'd2, 32'd1, 1, "R5");
        idle(14, 1, "R5");

        // R9: start already in the past
        step(1'b1, 2'd2, 32'd0, 1, "R6");
        step(1'b1, 2'd0, 32'd5, 1, "R9");
        step(1'b1, 2'd2, 32'd2, 1, "R9");
        idle(10, 1, "R9");

        // R7: start writes while running have no effect
        step(1'b1, 2'd0, 32'hFFFF_0000, 1, "R7");
        step(1'b1, 2'd1, 32'd7, 1, "R7");
        idle(12, 1, "R7");
        // R10: select 3 ignored while running
        step(1'b1, 2'd3, 32'd0, 1, "R10");
        idle(8, 1, "R10");
        // R8: restart uses the newer start (far future) -> stays low
        step(1'b1, 2'd2, 32'd5, 1, "R8");
        idle(20, 1, "R8");

        // R2/R4: start high word above time, low word below
        step(1'b1, 2'd2, 32'd0, 1, "R6");
        time_now = 64'h0000_0000_FFFF_FFF0;
        step(1'b1, 2'd0, 32'd4, 1, "R2");
        step(1'b1, 2'd1, 32'd1, 1, "R2");
        step(1'b1, 2'd2, 32'd4, 1, "R4");
        idle(50, 1, "R4");

        // constrained random mix
        step(1'b1, 2'd2, 32'd0, 1, "R6");
        time_now = 64'h0000_0001_FFFF_FF80;
        for (int i = 0; i < 3000; i++) begin
            int a;
            a = int'($urandom % 24);
            if (a == 0)
                step(1'b1, 2'd2, 32'($urandom % 7), int'($urandom % 3), "R5");
            else if (a == 1)
                step(1'b1, 2'd0, 32'(time_now[31:0] + 32'($urandom % 40)), int'($urandom % 3), "R7");
            else if (a == 2)
                step(1'b1, 2'd1, 32'(time_now[63:32] + 32'($urandom % 2)), int'($urandom % 3), "R7");
            else if (a == 3)
                step(1'b1, 2'd3, $urandom, int'($urandom % 3), "R10");
            else
                step(1'b0, 2'd0, '0, int'($urandom % 3), "R5");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule